// File: doc/BRIEF.md
# Predicated Mixed-Sign Saturating Vector Adder

This block is one execution slice of a vector datapath. It takes two operand vectors of a parameterized length, a per-byte predicate mask and a 2-bit lane-size code. In every active lane it treats the element of the first operand as unsigned and the element of the second operand as signed. It adds the two at full precision and clamps the sum to the unsigned range of the lane. Lanes whose predicate is off return the first operand's element unchanged. The output vector therefore stands in for the updated first operand.

The lane width is chosen per operation. Code 00 selects 8-bit lanes, 01 selects 16, 10 selects 32 and 11 selects 64. The number of lanes is the vector length divided by the lane width. An operation is presented with `valid_i`. Its result and `valid_o` appear one clock later, and the result stays on `res_o` until the next operation.

Top module: `mixsat_vec_add`

## Requirements
- R1: In an active N-bit lane whose sum lies in 0 to 2^N−1, the lane of `res_o` equals the unsigned value of the `opa_i` lane plus the two's-complement value of the `opb_i` lane. This includes sums exactly equal to 0 and to 2^N−1.
- R2: In an active lane whose sum is negative, the result lane is 0.
- R3: In an active N-bit lane whose sum exceeds 2^N−1, the result lane is all ones.
- R4: In an inactive lane, the result lane equals the `opa_i` lane, whatever the value of `opb_i`.
- R5: `size_i` sets the lane width N to 8 << `size_i`: 2'b00 gives 8, 2'b01 gives 16, 2'b10 gives 32 and 2'b11 gives 64. Lane e occupies bits [e·N +: N].
- R6: Lane e is active exactly when `pred_i[e·N/8]` is 1. This is the predicate bit of the lowest byte of the lane. The other predicate bits of the lane have no effect.
- R7: `valid_o` is 1 in the cycle after each cycle with `valid_i` high and is 0 otherwise. `valid_o` is 0 after reset.
- R8: `res_o` is 0 after reset. It keeps its value through cycles with `valid_i` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| size_i | input | 2 | Lane size code |
| opa_i | input | VLEN | Unsigned operand; merge source |
| opb_i | input | VLEN | Signed operand |
| pred_i | input | VLEN/8 | Predicate, one bit per byte |
| valid_o | output | 1 | Result valid, one clock after `valid_i` |
| res_o | output | VLEN | Result vector |

## Verification
The bench builds the block with VLEN = 192 rather than the default 128. With that length the 64-bit lane count is odd (three lanes), so lane slicing that quietly assumes a power-of-two vector would give wrong results. For every size code, the bench places sums exactly at 0, exactly at 2^N−1, one below zero and one above the maximum. It also applies predicate patterns that set only the non-lowest bytes of each lane. This exposes a lane decoder that reads the wrong predicate bit.

// File: rtl/msa_pkg.sv
package msa_pkg;
  typedef enum logic [1:0] {
    SZ_B = 2'b00,
    SZ_H = 2'b01,
    SZ_W = 2'b10,
    SZ_D = 2'b11
  } lane_sz_e;

  localparam int unsigned NUM_SZ = 4;
  localparam int unsigned MAX_W  = 64;

  function automatic int unsigned sz_bits(int unsigned code);
    return 8 << code;
  endfunction
endpackage

// File: rtl/msa_lane.sv
module msa_lane #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         act_i,
  output logic [W-1:0] y_o
);
  // W+2 bits: top bit is sign, bit W is carry past the lane range
  logic [W+1:0] sum;

  always_comb begin
    sum = {2'b00, a_i} + {{2{b_i[W-1]}}, b_i};
    if (!act_i)        y_o = a_i;
    else if (sum[W+1]) y_o = '0;
    else if (sum[W])   y_o = '1;
    else               y_o = sum[W-1:0];
  end
endmodule

// File: rtl/msa_width_bank.sv
module msa_width_bank #(
  parameter int unsigned VLEN = 128,
  parameter int unsigned W    = 8,
  localparam int unsigned LANES = VLEN / W
) (
  input  logic [VLEN-1:0]  a_i,
  input  logic [VLEN-1:0]  b_i,
  input  logic [LANES-1:0] act_i,
  output logic [VLEN-1:0]  y_o
);
  for (genvar e = 0; e < LANES; e++) begin : g_lane
    msa_lane #(.W(W)) u_lane (
      .a_i  (a_i[e*W +: W]),
      .b_i  (b_i[e*W +: W]),
      .act_i(act_i[e]),
      .y_o  (y_o[e*W +: W])
    );
  end
endmodule

// File: rtl/msa_size_mux.sv
module msa_size_mux
  import msa_pkg::*;
#(
  parameter int unsigned VLEN = 128
) (
  input  logic [NUM_SZ*VLEN-1:0] cand_i,
  input  lane_sz_e               size_i,
  output logic [VLEN-1:0]        y_o
);
  always_comb begin
    unique case (size_i)
      SZ_B:    y_o = cand_i[0*VLEN +: VLEN];
      SZ_H:    y_o = cand_i[1*VLEN +: VLEN];
      SZ_W:    y_o = cand_i[2*VLEN +: VLEN];
      default: y_o = cand_i[3*VLEN +: VLEN];
    endcase
  end
endmodule

// File: rtl/mixsat_vec_add.sv
module mixsat_vec_add
  import msa_pkg::*;
#(
  parameter int unsigned VLEN = 128,
  localparam int unsigned PLEN = VLEN / 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [1:0]      size_i,
  input  logic [VLEN-1:0] opa_i,
  input  logic [VLEN-1:0] opb_i,
  input  logic [PLEN-1:0] pred_i,
  output logic            valid_o,
  output logic [VLEN-1:0] res_o
);
  logic [NUM_SZ*VLEN-1:0] cand;
  logic [VLEN-1:0]        sel;
  logic                   valid_q;
  logic [VLEN-1:0]        res_q;

  for (genvar s = 0; s < NUM_SZ; s++) begin : g_sz
    localparam int unsigned W     = sz_bits(s);
    localparam int unsigned LANES = VLEN / W;
    logic [LANES-1:0] act;
    // lane activity from the predicate bit of the lane's lowest byte
    for (genvar e = 0; e < LANES; e++) begin : g_act
      assign act[e] = pred_i[e*(W/8)];
    end
    msa_width_bank #(.VLEN(VLEN), .W(W)) u_bank (
      .a_i  (opa_i),
      .b_i  (opb_i),
      .act_i(act),
      .y_o  (cand[s*VLEN +: VLEN])
    );
  end

  msa_size_mux #(.VLEN(VLEN)) u_mux (
    .cand_i(cand),
    .size_i(lane_sz_e'(size_i)),
    .y_o   (sel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      res_q   <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) res_q <= sel;
    end
  end

  assign valid_o = valid_q;
  assign res_o   = res_q;
endmodule

// File: rtl/msa_chk.sv
module msa_chk #(
  parameter int unsigned VLEN = 128,
  localparam int unsigned PLEN = VLEN / 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [1:0]      size_i,
  input logic [VLEN-1:0] opa_i,
  input logic [VLEN-1:0] opb_i,
  input logic [PLEN-1:0] pred_i,
  input logic            valid_o,
  input logic [VLEN-1:0] res_o
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R7
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R7
  AST_RES_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(res_o)); // R8

  for (genvar i = 0; i < PLEN; i++) begin : g_byte
    AST_BYTE_MERGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && size_i == 2'b00 && !pred_i[i])
      |=> res_o[8*i +: 8] == $past(opa_i[8*i +: 8])); // R4
    AST_BYTE_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && size_i == 2'b00 && pred_i[i] && !opb_i[8*i+7])
      |=> res_o[8*i +: 8] >= $past(opa_i[8*i +: 8])); // R3
    AST_BYTE_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && size_i == 2'b00 && pred_i[i] && opb_i[8*i+7])
      |=> res_o[8*i +: 8] < $past(opa_i[8*i +: 8]) || res_o[8*i +: 8] == 8'h00); // R2
  end

  for (genvar j = 0; j < VLEN/64; j++) begin : g_dw
    AST_DW_MERGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && size_i == 2'b11 && !pred_i[8*j])
      |=> res_o[64*j +: 64] == $past(opa_i[64*j +: 64])); // R6
  end
endmodule

bind mixsat_vec_add msa_chk #(.VLEN(VLEN)) u_chk (.*);

// File: tb/sim_mixsat_vec_add.sv
module sim_mixsat_vec_add;
  localparam int unsigned VL = 192;
  localparam int unsigned PL = VL / 8;

  typedef struct {
    logic [VL-1:0] res;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid_i = 1'b0;
  logic [1:0]    size_i = '0;
  logic [VL-1:0] opa_i = '0, opb_i = '0;
  logic [PL-1:0] pred_i = '0;
  logic          valid_o;
  logic [VL-1:0] res_o;

  int            checks = 0, fails = 0;
  exp_t          q[$];
  logic [VL-1:0] last_exp = '0;
  logic [VL-1:0] va, vb;
  logic [PL-1:0] vp;
  bit            done = 0;

  always #5 clk = ~clk;

  mixsat_vec_add #(.VLEN(VL)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .size_i(size_i),
    .opa_i(opa_i), .opb_i(opb_i), .pred_i(pred_i),
    .valid_o(valid_o), .res_o(res_o)
  );

  function automatic logic [VL-1:0] ref_calc(logic [VL-1:0] a, logic [VL-1:0] b,
                                             logic [PL-1:0] p, int sz);
    logic [VL-1:0] r;
    int w = 8 << sz;
    r = '0;
    for (int e = 0; e < VL / w; e++) begin
      logic signed [67:0] ua, sb, s, mx, o;
      ua = '0; sb = '0;
      for (int k = 0; k < 68; k++) begin
        if (k < w) begin ua[k] = a[e*w+k]; sb[k] = b[e*w+k]; end
        else sb[k] = b[e*w+w-1];
      end
      s  = ua + sb;
      mx = (68'sd1 <<< w) - 68'sd1;
      if (!p[e*w/8]) o = ua;
      else if (s < 0) o = '0;
      else if (s > mx) o = mx;
      else o = s;
      for (int k = 0; k < w; k++) r[e*w+k] = o[k];
    end
    return r;
  endfunction

  function automatic logic [VL-1:0] rnd_vec();
    logic [VL-1:0] v;
    for (int i = 0; i < VL / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic set_lane(ref logic [VL-1:0] v, input int e, input int w,
                          input logic [63:0] val);
    for (int k = 0; k < w; k++) v[e*w+k] = val[k];
  endtask

  task automatic apply(input logic [VL-1:0] a, input logic [VL-1:0] b,
                       input logic [PL-1:0] p, input int sz, input string tag);
    exp_t it;
    @(negedge clk);
    opa_i = a; opb_i = b; pred_i = p; size_i = 2'(sz); valid_i = 1'b1;
    it.res = ref_calc(a, b, p, sz);
    it.tag = tag;
    last_exp = it.res;
    q.push_back(it);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    valid_i = 1'b0;
    opb_i = rnd_vec(); opa_i = rnd_vec(); pred_i = '1;
    repeat (n - 1) @(negedge clk);
  endtask

  // monitor: compare each result as it appears
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      checks++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL R7: unexpected valid_o, got res %h expected none", res_o);
      end else begin
        exp_t it;
        it = q.pop_front();
        if (res_o !== it.res) begin
          fails++;
          $display("FAIL %s: res %h expected %h", it.tag, res_o, it.res);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: timeout, got running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (valid_o !== 1'b0 || res_o !== '0) begin
      fails++;
      $display("FAIL R7 R8: reset valid %b res %h expected 0 0", valid_o, res_o);
    end
    rst_n = 1'b1;
    @(negedge clk);

    for (int sz = 0; sz < 4; sz++) begin
      int w = 8 << sz;
      logic [63:0] mx = (64'd1 << w) - 64'd1;
      // R1 R5: all lanes active, random data
      apply(rnd_vec(), rnd_vec(), '1, sz, "R1/R5 random");
      // R1: exact 0
      va = rnd_vec(); vb = rnd_vec();
      set_lane(va, 0, w, 64'd5); set_lane(vb, 0, w, -64'sd5);
      apply(va, vb, '1, sz, "R1 exact zero");
      // R1: exact max
      va = rnd_vec(); vb = rnd_vec();
      set_lane(va, 0, w, mx - 64'd1); set_lane(vb, 0, w, 64'd1);
      apply(va, vb, '1, sz, "R1 exact max");
      // R2: just below zero and far below
      va = rnd_vec(); vb = rnd_vec();
      set_lane(va, 0, w, 64'd3); set_lane(vb, 0, w, -64'sd4);
      set_lane(va, 1, w, 64'd0); set_lane(vb, 1, w, 64'd1 << (w - 1));
      apply(va, vb, '1, sz, "R2 below zero");
      // R3: just above max and far above
      va = rnd_vec(); vb = rnd_vec();
      set_lane(va, 0, w, mx); set_lane(vb, 0, w, 64'd1);
      set_lane(va, 1, w, mx); set_lane(vb, 1, w, (64'd1 << (w - 1)) - 64'd1);
      apply(va, vb, '1, sz, "R3 above max");
      // R4: random predicate
      apply(rnd_vec(), rnd_vec(), PL'(rnd_vec()), sz, "R4 random pred");
      // R4: nothing active
      apply(rnd_vec(), rnd_vec(), '0, sz, "R4 all inactive");
      // R6: only non-lowest bytes of each lane set
      vp = '1;
      for (int e = 0; e < VL / w; e++) vp[e*w/8] = 1'b0;
      apply(rnd_vec(), rnd_vec(), vp, sz, "R6 upper bytes only");
      // R6: only lowest bytes set
      apply(rnd_vec(), rnd_vec(), ~vp, sz, "R6 lowest bytes only");
    end

    // gap then hold check
    idle(3);
    checks++;
    if (res_o !== last_exp || valid_o !== 1'b0) begin
      fails++;
      $display("FAIL R8: hold res %h valid %b expected %h 0", res_o, valid_o, last_exp);
    end

    // R5 R1: mixed sizes back to back
    for (int i = 0; i < 60; i++) begin
      apply(rnd_vec(), rnd_vec(), PL'(rnd_vec()), int'($urandom % 4), "R5 mixed sizes");
      if (i % 7 == 3) idle(2);
    end
    idle(3);
    checks++;
    if (res_o !== last_exp || q.size() != 0) begin
      fails++;
      $display("FAIL R8: final res %h pending %0d expected %h 0", res_o, q.size(), last_exp);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule